// File: doc/BRIEF.md
# Two-Format Register Processor Core

This block is a 16-bit processor core that completes one instruction per clock. It holds two working registers, an address register A and a data register D, and a program counter. A memory operand, M, always names the data-memory word whose address is the current contents of A. Instruction words come in on a read-only port that is addressed by the program counter. Data memory is reached through an address, a write-data bus, a write enable and a read-data bus. Both memories are expected to return read data combinationally, in the same cycle.

There are two instruction formats. A constant instruction places a 15-bit value into A. A compute instruction applies one of eighteen functions to D and to a second operand, which is either A or M. It sends the result to any mix of A, D and M. It may also redirect the program counter to A, depending on how the result compares with zero. The core is meant to sit between a program ROM and a data RAM; the surrounding system maps its peripherals into the data space.

Top module: `dual_reg_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, A and D to zero, so after reset `imem_addr` and `dmem_addr` are both 0.
- R2: When instruction bit 15 is 0, A takes bits 14..0 of the instruction with bit 15 of A cleared, `dmem_we` stays low, and the program counter advances by one.
- R3: When bit 15 is 1, the word is a compute instruction; bits 14 and 13 have no effect on its behaviour.
- R4: In a compute instruction, bit 12 picks the second operand: 0 takes A, 1 takes `dmem_rdata`, which is the memory word at the address held in A.
- R5: Bits 11..6 select the result: 101010 gives 0, 111111 gives 1, 111010 gives -1, 001100 gives D, 110000 gives Y, 001101 gives ~D, 110001 gives ~Y, 001111 gives -D, 110011 gives -Y, 011111 gives D+1, 110111 gives Y+1, 001110 gives D-1, 110010 gives Y-1, 000010 gives D+Y, 010011 gives D-Y, 000111 gives Y-D, 000000 gives D&Y, and 010101 gives D|Y. Here Y is the operand picked by bit 12, and the arithmetic is 16-bit two's complement with wrap-around.
- R6: Bit 5 writes the result to A, bit 4 writes it to D, and bit 3 raises `dmem_we` with `dmem_wdata` equal to the result. Any combination of these bits is legal, including none.
- R7: `dmem_addr` always shows the A value held before the current instruction executes. A memory write therefore goes to the old A, even when the same instruction also writes A.
- R8: Bit 2 enables a jump when the result is negative, bit 1 enables one when it is zero, and bit 0 enables one when it is positive. On a jump, the program counter loads the pre-instruction A; otherwise it increments, wrapping at its width.
- R9: A result counts as negative when its bit 15 is set, as zero when all bits are clear, and as positive otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Program counter, the address of the instruction word |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | DADDR_W | Data address, taken from register A |
| dmem_wdata | output | 16 | Compute result, used as the write data |
| dmem_we | output | 1 | Data memory write enable |
| dmem_rdata | input | 16 | Data word at `dmem_addr`, used as operand M |

## Verification
The hardest case to reach from the ports is an instruction that writes A and M at once, or jumps while also writing A. In that case the old and new values of A must be told apart within a single cycle. A directed prologue builds these cases explicitly: it stores to an address and retargets A in the same step, and it jumps while overwriting A. After that, a long randomized stream mixes constant loads with compute words. That stream uses random ignored bits, random destination masks and random jump masks. A behavioural model tracks the program counter, the registers and its own copy of memory, and every cycle it predicts the instruction address, the data address, the write strobe and the write data.

// File: rtl/drc_pkg.sv
package drc_pkg;
  localparam int WORD_W  = 16;
  localparam int IMM_W   = 15;
  localparam int FMT_BIT = 15;
  localparam int SEL_BIT = 12;
  localparam int FN_LO   = 6;
  localparam int WA_BIT  = 5;
  localparam int WD_BIT  = 4;
  localparam int WM_BIT  = 3;

  typedef struct packed {
    logic zx;
    logic nx;
    logic zy;
    logic ny;
    logic f;
    logic no;
  } alu_ctl_t;

  typedef struct packed {
    logic             is_c;
    logic [IMM_W-1:0] imm;
    logic             sel_m;
    alu_ctl_t         alu;
    logic             wr_a;
    logic             wr_d;
    logic             wr_m;
    logic [2:0]       jmask;
  } ctl_t;
endpackage

// File: rtl/drc_decode.sv
module drc_decode
  import drc_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output ctl_t              ctl
);
  logic compute;
  assign compute = instr[FMT_BIT];

  always_comb begin
    ctl.is_c  = compute;
    ctl.imm   = instr[IMM_W-1:0];
    ctl.sel_m = instr[SEL_BIT];
    ctl.alu   = alu_ctl_t'(instr[FN_LO+5:FN_LO]);
    ctl.wr_a  = compute & instr[WA_BIT];
    ctl.wr_d  = compute & instr[WD_BIT];
    ctl.wr_m  = compute & instr[WM_BIT];
    ctl.jmask = compute ? instr[2:0] : 3'b000;
  end
endmodule

// File: rtl/drc_alu.sv
module drc_alu
  import drc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  alu_ctl_t     ctl,
  output logic [W-1:0] res,
  output logic         zr,
  output logic         ng
);
  logic [W-1:0] x_z, x_n, y_z, y_n, raw;

  always_comb begin
    x_z = ctl.zx ? '0 : x;
    x_n = ctl.nx ? ~x_z : x_z;
    y_z = ctl.zy ? '0 : y;
    y_n = ctl.ny ? ~y_z : y_z;
    raw = ctl.f ? (x_n + y_n) : (x_n & y_n);
    res = ctl.no ? ~raw : raw;
  end

  assign zr = (res == '0);
  assign ng = res[W-1];
endmodule

// File: rtl/drc_branch.sv
module drc_branch (
  input  logic [2:0] jmask,
  input  logic       zr,
  input  logic       ng,
  output logic       take
);
  logic pos;
  assign pos  = ~zr & ~ng;
  assign take = (jmask[2] & ng) | (jmask[1] & zr) | (jmask[0] & pos);
endmodule

// File: rtl/dual_reg_core.sv
module dual_reg_core
  import drc_pkg::*;
#(
  parameter int PC_W    = 15,
  parameter int DADDR_W = 15
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [WORD_W-1:0]  imem_data,
  output logic [DADDR_W-1:0] dmem_addr,
  output logic [WORD_W-1:0]  dmem_wdata,
  output logic               dmem_we,
  input  logic [WORD_W-1:0]  dmem_rdata
);
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  logic [WORD_W-1:0] a_q, d_q;
  logic [PC_W-1:0]   pc_q;
  ctl_t              ctl;
  logic [WORD_W-1:0] y_op, alu_res;
  logic              zr, ng, take;

  drc_decode u_dec (
    .instr (imem_data),
    .ctl   (ctl)
  );

  assign y_op = ctl.sel_m ? dmem_rdata : a_q;

  drc_alu #(.W(WORD_W)) u_alu (
    .x   (d_q),
    .y   (y_op),
    .ctl (ctl.alu),
    .res (alu_res),
    .zr  (zr),
    .ng  (ng)
  );

  drc_branch u_br (
    .jmask (ctl.jmask),
    .zr    (zr),
    .ng    (ng),
    .take  (take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      a_q  <= '0;
      d_q  <= '0;
    end else begin
      pc_q <= take ? a_q[PC_W-1:0] : pc_q + PC_ONE;
      if (!ctl.is_c)
        a_q <= {1'b0, ctl.imm};
      else if (ctl.wr_a)
        a_q <= alu_res;
      if (ctl.wr_d)
        d_q <= alu_res;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = a_q[DADDR_W-1:0];
  assign dmem_wdata = alu_res;
  assign dmem_we    = ctl.wr_m;

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc_q == PC_W'($past(pc_q) + PC_ONE));

  assert_pc_jump_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> pc_q == $past(a_q[PC_W-1:0]));

  assert_const_load_R2: assert property (@(posedge clk) disable iff (rst)
    !imem_data[FMT_BIT] |=> a_q == {1'b0, $past(imem_data[IMM_W-1:0])});

  assert_const_nowrite_R2: assert property (@(posedge clk) disable iff (rst)
    !imem_data[FMT_BIT] |-> !dmem_we);

  assert_dreg_update_R6: assert property (@(posedge clk) disable iff (rst)
    (imem_data[FMT_BIT] && imem_data[WD_BIT]) |=> d_q == $past(alu_res));
endmodule

// File: tb/tb_dual_reg_core.sv
module tb_dual_reg_core;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PC_W    = 15;
  localparam int DADDR_W = 15;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [PC_W-1:0]    imem_addr;
  logic [15:0]        imem_data = 16'h0000;
  logic [DADDR_W-1:0] dmem_addr;
  logic [15:0]        dmem_wdata;
  logic               dmem_we;
  logic [15:0]        dmem_rdata;

  dual_reg_core #(.PC_W(PC_W), .DADDR_W(DADDR_W)) dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  always #2.5 clk = ~clk;

  logic [15:0] dut_mem [256];
  logic [15:0] ref_mem [256];
  assign dmem_rdata = dut_mem[dmem_addr[7:0]];
  always @(posedge clk) if (dmem_we) dut_mem[dmem_addr[7:0]] <= dmem_wdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] ma = '0, md = '0;
  logic [14:0] mp = '0;

  logic [5:0] codes [18] = '{6'b101010, 6'b111111, 6'b111010, 6'b001100,
    6'b110000, 6'b001101, 6'b110001, 6'b001111, 6'b110011, 6'b011111,
    6'b110111, 6'b001110, 6'b110010, 6'b000010, 6'b010011, 6'b000111,
    6'b000000, 6'b010101};

  // R5: meaning of each function code, written from the list
  function automatic logic [15:0] ref_fn(input logic [5:0] c,
                                         input logic [15:0] d, input logic [15:0] y);
    case (c)
      6'b101010: return 16'd0;
      6'b111111: return 16'd1;
      6'b111010: return 16'hFFFF;
      6'b001100: return d;
      6'b110000: return y;
      6'b001101: return ~d;
      6'b110001: return ~y;
      6'b001111: return 16'd0 - d;
      6'b110011: return 16'd0 - y;
      6'b011111: return d + 16'd1;
      6'b110111: return y + 16'd1;
      6'b001110: return d - 16'd1;
      6'b110010: return y - 16'd1;
      6'b000010: return d + y;
      6'b010011: return d - y;
      6'b000111: return y - d;
      6'b000000: return d & y;
      6'b010101: return d | y;
      default:   return 16'hxxxx;
    endcase
  endfunction

  function automatic logic [15:0] mkc(input logic a, input logic [5:0] c,
                                      input logic [2:0] dst, input logic [2:0] j);
    return {3'b111, a, c, dst, j};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] ins);
    logic [15:0] y, r;
    logic lt, eq, gt, jmp;
    imem_data = ins;
    #1;
    chk("R8 instruction address", 32'(imem_addr), 32'(mp));
    chk("R7 data address is old A", 32'(dmem_addr), 32'(ma[14:0]));
    if (!ins[15]) begin
      chk("R2 constant load must not write", 32'(dmem_we), 32'd0);
      ma = {1'b0, ins[14:0]};
      mp = mp + 15'd1;
    end else begin
      y = ins[12] ? ref_mem[ma[7:0]] : ma;       // R4 operand pick
      r = ref_fn(ins[11:6], md, y);
      chk("R6 write strobe", 32'(dmem_we), 32'(ins[3]));
      if (ins[3]) chk("R5 result on write data", 32'(dmem_wdata), 32'(r));
      lt = r[15];                                 // R9 sign rule
      eq = (r == 16'd0);
      gt = !lt && !eq;
      jmp = (ins[2] && lt) || (ins[1] && eq) || (ins[0] && gt);
      if (ins[3]) ref_mem[ma[7:0]] = r;
      mp = jmp ? ma[14:0] : mp + 15'd1;
      if (ins[5]) ma = r;
      if (ins[4]) md = r;
    end
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      dut_mem[i] = 16'(i * 37 + 5);
      ref_mem[i] = 16'(i * 37 + 5);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 reset program counter", 32'(imem_addr), 32'd0);
    chk("R1 reset data address", 32'(dmem_addr), 32'd0);
    rst = 1'b0;

    // directed prologue
    step(16'd5);
    step(mkc(1'b0, 6'b110000, 3'b010, 3'b000));   // D=A
    step(16'd7);
    step(mkc(1'b0, 6'b001100, 3'b001, 3'b000));   // M=D
    step(mkc(1'b0, 6'b011111, 3'b101, 3'b000));   // R7: A and M together
    step(mkc(1'b1, 6'b110000, 3'b010, 3'b000));   // D=M at new A
    step(16'd40);
    step(mkc(1'b0, 6'b101010, 3'b000, 3'b111));   // unconditional jump
    step(16'd3);
    step(mkc(1'b0, 6'b111010, 3'b000, 3'b100));   // -1, jump if negative
    step(mkc(1'b0, 6'b111111, 3'b000, 3'b011));   // 1, jump if >= 0
    step(mkc(1'b0, 6'b101010, 3'b000, 3'b101));   // 0, jump if != 0: no jump
    step(16'd9);
    step(mkc(1'b0, 6'b111111, 3'b100, 3'b111));   // R8: jump uses old A
    step(16'h7FFF);
    step({3'b101, 1'b0, 6'b110000, 3'b010, 3'b000}); // R3: bits 14..13 ignored

    // randomized stream
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        step(16'($urandom_range(0, 300)));
      end else begin
        step({1'b1, 2'($urandom_range(0, 3)),       // R3 random ignored bits
              1'($urandom_range(0, 1)),
              codes[$urandom_range(0, 17)],
              3'($urandom_range(0, 7)),
              3'($urandom_range(0, 7))});
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule